// File: doc/BRIEF.md
# Signed-Magnitude Adder-Subtractor

This block adds or subtracts two W-bit numbers held in signed-magnitude form (W is 8 by default). In each operand the top bit is the sign and the W-1 bits below it are an unsigned magnitude. A single control pin chooses addition or subtraction. The block peels the sign off each operand. For a subtraction it flips the sign of the second operand. It then decides from the two effective signs whether the magnitudes are summed or differenced.

When the effective signs match, the magnitudes are summed and the result carries the shared sign. A carry out of the magnitude field raises the overflow flag. When the signs differ, the first magnitude has the second taken from it. An end borrow means the second magnitude was larger: the raw difference is then two's-complemented to recover the true magnitude, and the result takes the second operand's effective sign. A zero magnitude is always given a positive sign.

The block is purely combinational. It has no clock, no reset and no handshake, and the result follows its inputs within the same cycle.

Top module: `sm_addsub`

## Requirements
- R1: Operand and result encoding: bit W-1 is the sign (0 positive, 1 negative) and bits W-2..0 are an unsigned magnitude; with W=8, +9 is 8'b0000_1001 and -9 is 8'b1000_1001.
- R2: With equal effective signs, the result magnitude is the low W-1 bits of the sum of the two magnitudes, and the result sign is the shared sign (unless R7 applies).
- R3: `ovf` is 1 exactly when the effective signs match and the magnitude sum reaches 2^(W-1) or more.
- R4: `op_sub`=1 selects subtraction, which inverts the second operand's sign before the add-or-subtract choice; `op_sub`=0 selects addition and leaves it as it is.
- R5: With differing effective signs and magnitude of `op_a` at least that of `op_b`, the result magnitude is their difference and the sign is that of `op_a` (unless R7 applies).
- R6: With differing effective signs and magnitude of `op_a` below that of `op_b`, the end borrow triggers a two's-complement fix-up: the result magnitude is mag(b)-mag(a) and the sign is the effective sign of `op_b`. Example: 8'b0001_1001 plus 8'b1010_0101 gives 8'b1000_1100.
- R7: Whenever the result magnitude is zero, the result sign bit is 0; negative zero never appears on `res`.
- R8: `ovf` is never 1 when the effective signs differ.
- R9: The block is combinational: `res` and `ovf` reflect the current inputs with no register in the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | W | First operand (minuend for subtraction), signed-magnitude |
| op_b | input | W | Second operand (subtrahend for subtraction), signed-magnitude |
| op_sub | input | 1 | 0 selects add, 1 selects subtract |
| res | output | W | Signed-magnitude result |
| ovf | output | 1 | Magnitude overflow on a same-sign sum |

## Verification
Every result of this block is due in the same cycle as the stimulus that causes it, because no register lies between the operand pins and `res` or `ovf`. The bench changes the inputs on the falling clock edge and samples both outputs one nanosecond later, well before the next rising edge. The path has then settled, and no sample can pick up a value from an earlier input set. Expected values come from an integer model of the signed values, reduced modulo the magnitude range, and this model is independent of the sign-select structure in the RTL.

// File: rtl/sm_pkg.sv
package sm_pkg;
  typedef enum logic {
    SM_OP_ADD = 1'b0,
    SM_OP_SUB = 1'b1
  } sm_op_e;

  typedef enum logic {
    SM_PATH_SUM  = 1'b0,
    SM_PATH_DIFF = 1'b1
  } sm_path_e;
endpackage

// File: rtl/sm_split.sv
module sm_split #(
  parameter int W = 8,
  localparam int MW = W - 1
) (
  input  logic [W-1:0]  op_a,
  input  logic [W-1:0]  op_b,
  input  logic          op_sub,
  output logic          sgn_a,
  output logic          sgn_b_eff,
  output logic [MW-1:0] mag_a,
  output logic [MW-1:0] mag_b,
  output sm_pkg::sm_path_e path
);
  import sm_pkg::*;

  sm_op_e op;

  always_comb begin
    op        = sm_op_e'(op_sub);
    sgn_a     = op_a[W-1];
    mag_a     = op_a[MW-1:0];
    mag_b     = op_b[MW-1:0];
    sgn_b_eff = (op == SM_OP_SUB) ? ~op_b[W-1] : op_b[W-1];
    path      = (sgn_a == sgn_b_eff) ? SM_PATH_SUM : SM_PATH_DIFF;
  end

  // R4: subtract mode flips the second sign relative to its input bit
  always_comb begin
    if (op_sub) p_sub_flip_r4: assert (sgn_b_eff != op_b[W-1]);
    else        p_add_keep_r4: assert (sgn_b_eff == op_b[W-1]);
  end
endmodule

// File: rtl/sm_ripple.sv
module sm_ripple #(
  parameter int MW = 7
) (
  input  logic [MW-1:0] a,
  input  logic [MW-1:0] b,
  input  logic          diff_mode,
  output logic [MW-1:0] raw,
  output logic          cout
);
  logic [MW:0]   c;
  logic [MW-1:0] bx;

  assign c[0] = diff_mode;

  for (genvar i = 0; i < MW; i++) begin : g_fa
    logic p;
    assign bx[i]   = b[i] ^ diff_mode;
    assign p       = a[i] ^ bx[i];
    assign raw[i]  = p ^ c[i];
    assign c[i+1]  = (a[i] & bx[i]) | (p & c[i]);
  end

  assign cout = c[MW];

  // R2: sum path matches arithmetic sum including carry
  // R5: difference path without borrow matches arithmetic difference
  always_comb begin
    if (!diff_mode)
      p_sum_exact_r2: assert ({cout, raw} == ({1'b0, a} + {1'b0, b}));
    else if (cout)
      p_diff_exact_r5: assert (raw == a - b);
  end
endmodule

// File: rtl/sm_fixup.sv
module sm_fixup #(
  parameter int MW = 7
) (
  input  logic [MW-1:0]     raw,
  input  logic              cout,
  input  sm_pkg::sm_path_e  path,
  input  logic              sgn_a,
  input  logic              sgn_b_eff,
  output logic [MW-1:0]     mag_o,
  output logic              sgn_o,
  output logic              ovf_o
);
  import sm_pkg::*;

  logic          borrow;
  logic [MW-1:0] inv;
  logic [MW-1:0] neg;
  logic [MW:0]   ic;
  logic          sgn_pre;

  assign inv   = ~raw;
  assign ic[0] = 1'b1;

  for (genvar i = 0; i < MW; i++) begin : g_inc
    assign neg[i]  = inv[i] ^ ic[i];
    assign ic[i+1] = inv[i] & ic[i];
  end

  always_comb begin
    borrow  = (path == SM_PATH_DIFF) && !cout;
    mag_o   = borrow ? neg : raw;
    sgn_pre = borrow ? sgn_b_eff : sgn_a;
    sgn_o   = (mag_o == '0) ? 1'b0 : sgn_pre;
    ovf_o   = (path == SM_PATH_SUM) && cout;
  end

  // R7: no negative zero; R6: a fix-up never yields zero magnitude
  always_comb begin
    p_no_neg_zero_r7: assert (!(mag_o == '0 && sgn_o));
    if (borrow) p_fix_nonzero_r6: assert (mag_o != '0);
  end
endmodule

// File: rtl/sm_addsub.sv
module sm_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         op_sub,
  output logic [W-1:0] res,
  output logic         ovf
);
  import sm_pkg::*;

  localparam int MW = W - 1;

  logic          sgn_a;
  logic          sgn_b_eff;
  logic [MW-1:0] mag_a;
  logic [MW-1:0] mag_b;
  sm_path_e      path;
  logic [MW-1:0] raw;
  logic          cout;
  logic [MW-1:0] mag_r;
  logic          sgn_r;

  sm_split #(.W(W)) u_split (
    .op_a      (op_a),
    .op_b      (op_b),
    .op_sub    (op_sub),
    .sgn_a     (sgn_a),
    .sgn_b_eff (sgn_b_eff),
    .mag_a     (mag_a),
    .mag_b     (mag_b),
    .path      (path)
  );

  sm_ripple #(.MW(MW)) u_ripple (
    .a         (mag_a),
    .b         (mag_b),
    .diff_mode (path == SM_PATH_DIFF),
    .raw       (raw),
    .cout      (cout)
  );

  sm_fixup #(.MW(MW)) u_fixup (
    .raw       (raw),
    .cout      (cout),
    .path      (path),
    .sgn_a     (sgn_a),
    .sgn_b_eff (sgn_b_eff),
    .mag_o     (mag_r),
    .sgn_o     (sgn_r),
    .ovf_o     (ovf)
  );

  assign res = {sgn_r, mag_r};

  // R8: differing signs never flag overflow
  // R6: smaller first magnitude gives mag(b)-mag(a)
  always_comb begin
    if (op_a[W-1] != (op_b[W-1] ^ op_sub)) begin
      p_no_overflow_r8: assert (!ovf);
      if (op_a[MW-1:0] < op_b[MW-1:0])
        p_fix_mag_r6: assert (res[MW-1:0] == op_b[MW-1:0] - op_a[MW-1:0]);
    end
  end
endmodule

// File: tb/sm_addsub_tb_top.sv
`timescale 1ns/1ps
module sm_addsub_tb_top;
  localparam int W  = 8;
  localparam int MW = W - 1;
  localparam int MR = 1 << MW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic op_sub = 1'b0;
  logic [W-1:0] res;
  logic ovf;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sm_addsub #(.W(W)) dut_i (
    .op_a(op_a), .op_b(op_b), .op_sub(op_sub), .res(res), .ovf(ovf)
  );

  function automatic int val_of(logic [W-1:0] x);
    int m = int'(x[MW-1:0]);
    return x[W-1] ? -m : m;
  endfunction

  function automatic logic [W:0] model(logic [W-1:0] a, logic [W-1:0] b, logic sub);
    int s = sub ? val_of(a) - val_of(b) : val_of(a) + val_of(b);
    int am = (s < 0) ? -s : s;
    logic of = (am >= MR);
    int m = am % MR;
    logic sg = (m != 0) && (s < 0);
    return {of, sg, MW'(m)};
  endfunction

  task automatic apply(logic [W-1:0] a, logic [W-1:0] b, logic sub);
    @(negedge clk);
    op_a = a; op_b = b; op_sub = sub;
    #1;
  endtask

  task automatic chk(string req, logic [W:0] act, logic [W:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s a=%b b=%b sub=%b actual ovf/res=%b expected=%b",
               req, op_a, op_b, op_sub, act, exp);
    end
  endtask

  task automatic run_and_check(string req, logic [W-1:0] a, logic [W-1:0] b, logic sub);
    apply(a, b, sub);
    chk(req, {ovf, res}, model(a, b, sub));
  endtask

  task automatic t_reset_state();
    apply('0, '0, 1'b0);
    chk("R9 idle", {ovf, res}, {1'b0, 8'h00});
  endtask

  task automatic t_encoding();
    // R1: +9 and -9 encodings; R6 document vector
    run_and_check("R1 +9+-9", 8'b0000_1001, 8'b1000_1001, 1'b0);
    chk("R1 zero", {ovf, res}, 9'h000);
    apply(8'b0001_1001, 8'b1010_0101, 1'b0);
    chk("R6 vector", {ovf, res}, {1'b0, 8'b1000_1100});
  endtask

  task automatic t_same_sign();
    run_and_check("R2 pos", 8'd20, 8'd30, 1'b0);
    chk("R2 pos lit", {ovf, res}, {1'b0, 8'd50});
    run_and_check("R2 neg", 8'h80 | 8'd5, 8'h80 | 8'd7, 1'b0);
    chk("R2 neg lit", {ovf, res}, {1'b0, 8'h8C});
  endtask

  task automatic t_overflow();
    apply(8'd100, 8'd27, 1'b0);
    chk("R3 max no ovf", {ovf, res}, {1'b0, 8'd127});
    apply(8'd100, 8'd28, 1'b0);
    chk("R3 edge ovf", {ovf, res}, {1'b1, 8'd0});
    apply(8'h80 | 8'd100, 8'h80 | 8'd100, 1'b0);
    chk("R3 neg ovf", {ovf, res}, {1'b1, 8'h80 | 8'd72});
  endtask

  task automatic t_sub_mode();
    apply(8'd10, 8'd3, 1'b1);
    chk("R4 sub", {ovf, res}, {1'b0, 8'd7});
    apply(8'd10, 8'h80 | 8'd3, 1'b1);
    chk("R4 sub neg", {ovf, res}, {1'b0, 8'd13});
    apply(8'd120, 8'h80 | 8'd20, 1'b1);
    chk("R4 sub ovf R3", {ovf, res}, {1'b1, 8'd12});
  endtask

  task automatic t_diff_sign();
    apply(8'h80 | 8'd40, 8'd15, 1'b0);
    chk("R5 a larger", {ovf, res}, {1'b0, 8'h80 | 8'd25});
    apply(8'd3, 8'd90, 1'b1);
    chk("R6 borrow", {ovf, res}, {1'b0, 8'h80 | 8'd87});
    apply(8'd127, 8'h80 | 8'd127, 1'b0);
    chk("R8 no ovf", {ovf, res}, {1'b0, 8'd0});
  endtask

  task automatic t_zero();
    apply(8'h80 | 8'd33, 8'd33, 1'b0);
    chk("R7 cancel", {ovf, res}, {1'b0, 8'd0});
    apply(8'h80, 8'h80, 1'b0);
    chk("R7 negzero in", {ovf, res}, {1'b0, 8'd0});
    apply(8'h80 | 8'd64, 8'h80 | 8'd64, 1'b0);
    chk("R7 ovf zero R3", {ovf, res}, {1'b1, 8'd0});
  endtask

  task automatic t_sweep();
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b += 13)
        for (int s = 0; s < 2; s++)
          run_and_check("R2/R5 sweep", W'(a), W'(b), 1'(s));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_encoding();
    t_same_sign();
    t_overflow();
    t_sub_mode();
    t_diff_sign();
    t_zero();
    t_sweep();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule